// File: doc/BRIEF.md
# Flash Erase/Program Sequencer

This block sits on the host side of a byte-wide parallel flash device and turns a single request into the full bus activity for a byte program, a sector erase or a whole-chip erase. A request carries an operation code, an address and a data byte, and is taken on a valid/ready handshake. Only one request is in flight at a time.

Once a request is accepted, the sequencer plays out the unlock-and-command script as a series of bus writes. It drives the chip-select, write-strobe, address and data lines with pulse widths set in clock cycles. It then releases the data bus and polls the device with read strobes. Completion is found when bit 6 of two back-to-back reads agrees. A busy device inverts that bit on every read. The sequencer ends each operation with a one-cycle `done` pulse, or with an `err` pulse if the read limit for that operation runs out.

The controller has seven states. IDLE takes a request (IDLE→WR_LOW). WR_LOW holds the write strobe low (WR_LOW→WR_HIGH). WR_HIGH is the recovery time; it goes to WR_LOW for the next script step, or to TURN after the last step. TURN is a one-cycle gap with the data bus released (TURN→RD_LOW). RD_LOW holds the read strobe low and samples bit 6 in its last cycle. From RD_LOW the controller goes to FIN on a match, to ERR on a mismatch at the read limit, and to TURN otherwise. FIN and ERR each last one cycle and return to IDLE.

Top module: `flash_cmd_seq`

## Requirements
- R1: `req_ready` is high only in IDLE, and a request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the `done` or `err` pulse. Changes on the request inputs while busy have no effect.
- R2: Op code 00 (byte program) writes, in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the request address with the request data byte.
- R3: Op code 01 (sector erase) writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, and finally the sector base with 0x30. The sector base is request address bits 15:12 with bits 11:0 forced to zero (4 KByte sectors).
- R4: Op codes 10 and 11 (chip erase) write the same first five words as R3, then 0x5555/0x10 as the final write.
- R5: During each write, `f_we_n` is low for exactly WE_LOW cycles with `f_ce_n` low, `f_oe_n` high and the data bus driven. It is then high for WE_HIGH cycles, with address and data held.
- R6: The data bus enable is low for at least one cycle before `f_oe_n` falls, and it is never high while `f_oe_n` is low.
- R7: Each polling read holds `f_oe_n` low for RD_LOW cycles after one TURN cycle. The read address is the target address for a program, the sector base for a sector erase, and 0 for a chip erase. DQ6 is sampled in the last cycle of the read.
- R8: When a read returns the same DQ6 as the read before it, `done` pulses for one cycle and the bus goes idle.
- R9: If the read that reaches the operation's limit (LIM_PROG, LIM_SECT or LIM_CHIP) still differs from the read before it, `err` pulses for one cycle instead of `done`. A match on that same read still counts as done.
- R10: In reset, IDLE, FIN and ERR, `f_ce_n`, `f_oe_n` and `f_we_n` are high, the data bus is released, and the address and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_we_n | output | 1 | Flash write enable, active low |
| f_addr | output | AW | Flash address |
| f_dq_o | output | 8 | Data driven to the flash |
| f_dq_oe | output | 1 | Drive enable for f_dq_o |
| f_dq_i | input | 8 | Data read from the flash |

## Verification
The bench targets the edges of the polling limit. It uses a device that stops toggling exactly on the limit read, which a design with an off-by-one would report as a timeout. It also uses a device that toggles one read longer, which such a design would wrongly report as done. A busy device that never settles is used to catch a design that stops polling or never raises `err`. The bench holds `req_valid` high with altered fields while the sequencer is busy, so a design that re-latches the request would corrupt the later script words. It also checks that a sector address with low bits set is masked, and that op code 11 gives the chip-erase script rather than some other sequence.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG     = 2'b00,
        OP_SECT     = 2'b01,
        OP_CHIP     = 2'b10,
        OP_CHIP_ALT = 2'b11
    } flash_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_LOW,
        S_WR_HIGH,
        S_TURN,
        S_RD_LOW,
        S_FIN,
        S_ERR
    } seq_state_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_SET = 8'h80;
    localparam logic [7:0]  CMD_SECT_GO   = 8'h30;
    localparam logic [7:0]  CMD_CHIP_GO   = 8'h10;

    localparam int STEP_W = 3;

endpackage

// File: rtl/flash_cmd_script.sv
module flash_cmd_script
    import flash_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SECT_LSB = 12
) (
    input  flash_op_e          op,
    input  logic [STEP_W-1:0]  step,
    input  logic [AW-1:0]      tgt_addr,
    input  logic [7:0]         tgt_data,
    output logic [AW-1:0]      cmd_addr,
    output logic [7:0]         cmd_data,
    output logic               last_step,
    output logic [AW-1:0]      poll_addr
);
    localparam logic [AW-1:0] ADR_A = AW'(UNLOCK_ADDR_A);
    localparam logic [AW-1:0] ADR_B = AW'(UNLOCK_ADDR_B);

    logic [AW-1:0] sect_base;
    logic          is_prog;
    logic          is_sect;

    always_comb begin
        sect_base = {tgt_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
        is_prog   = (op == OP_PROG);
        is_sect   = (op == OP_SECT);
        last_step = is_prog ? (step == STEP_W'(3)) : (step == STEP_W'(5));

        if (is_prog)      poll_addr = tgt_addr;
        else if (is_sect) poll_addr = sect_base;
        else              poll_addr = '0;

        cmd_addr = ADR_A;
        cmd_data = KEY_FIRST;
        unique case (step)
            STEP_W'(0): begin
                cmd_addr = ADR_A;
                cmd_data = KEY_FIRST;
            end
            STEP_W'(1): begin
                cmd_addr = ADR_B;
                cmd_data = KEY_SECOND;
            end
            STEP_W'(2): begin
                cmd_addr = ADR_A;
                cmd_data = is_prog ? CMD_PROGRAM : CMD_ERASE_SET;
            end
            STEP_W'(3): begin
                cmd_addr = is_prog ? tgt_addr : ADR_A;
                cmd_data = is_prog ? tgt_data : KEY_FIRST;
            end
            STEP_W'(4): begin
                cmd_addr = ADR_B;
                cmd_data = KEY_SECOND;
            end
            default: begin
                cmd_addr = is_sect ? sect_base : ADR_A;
                cmd_data = is_sect ? CMD_SECT_GO : CMD_CHIP_GO;
            end
        endcase
    end

endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] len,
    output logic          last
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + TW'(1);
    end

    assign last = (cnt == (len - TW'(1)));

endmodule

// File: rtl/flash_toggle_poll.sv
module flash_toggle_poll #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic          dq6,
    input  logic [CW-1:0] limit,
    output logic          match,
    output logic          at_limit
);
    logic          prev_bit;
    logic          have_prev;
    logic [CW-1:0] reads_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_bit   <= 1'b0;
            have_prev  <= 1'b0;
            reads_done <= '0;
        end else if (clear) begin
            prev_bit   <= 1'b0;
            have_prev  <= 1'b0;
            reads_done <= '0;
        end else if (sample) begin
            prev_bit   <= dq6;
            have_prev  <= 1'b1;
            reads_done <= reads_done + CW'(1);
        end
    end

    assign match    = have_prev && (prev_bit == dq6);
    assign at_limit = ((reads_done + CW'(1)) == limit);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SECT_LSB = 12,
    parameter int WE_LOW   = 4,
    parameter int WE_HIGH  = 3,
    parameter int RD_LOW   = 4,
    parameter int LIM_PROG = 2000,
    parameter int LIM_SECT = 500000,
    parameter int LIM_CHIP = 1000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          err,
    output logic          f_ce_n,
    output logic          f_oe_n,
    output logic          f_we_n,
    output logic [AW-1:0] f_addr,
    output logic [7:0]    f_dq_o,
    output logic          f_dq_oe,
    input  logic [7:0]    f_dq_i
);
    localparam int PH_MAX01 = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
    localparam int PH_MAX   = (PH_MAX01 > RD_LOW) ? PH_MAX01 : RD_LOW;
    localparam int TW       = $clog2(PH_MAX + 1);
    localparam int LIM_M01  = (LIM_PROG > LIM_SECT) ? LIM_PROG : LIM_SECT;
    localparam int LIM_MAX  = (LIM_M01 > LIM_CHIP) ? LIM_M01 : LIM_CHIP;
    localparam int CW       = $clog2(LIM_MAX + 1);

    seq_state_e        state, nxt;
    flash_op_e         op_q;
    logic [AW-1:0]     addr_q;
    logic [7:0]        data_q;
    logic [STEP_W-1:0] step_q;

    logic [AW-1:0] cmd_addr, poll_addr;
    logic [7:0]    cmd_data;
    logic          last_step;
    logic [TW-1:0] ph_len;
    logic          ph_last;
    logic [CW-1:0] limit;
    logic          match, at_limit;
    logic          accept, sample;
    logic          dq_unused;

    assign dq_unused = ^{f_dq_i[7], f_dq_i[5:0]};
    assign accept    = req_valid && (state == S_IDLE);
    assign sample    = (state == S_RD_LOW) && ph_last;

    flash_cmd_script #(.AW(AW), .SECT_LSB(SECT_LSB)) u_script (
        .op        (op_q),
        .step      (step_q),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .last_step (last_step),
        .poll_addr (poll_addr)
    );

    flash_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nxt != state),
        .len     (ph_len),
        .last    (ph_last)
    );

    flash_toggle_poll #(.CW(CW)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample   (sample),
        .dq6      (f_dq_i[6]),
        .limit    (limit),
        .match    (match),
        .at_limit (at_limit)
    );

    always_comb begin
        unique case (state)
            S_WR_LOW:  ph_len = TW'(WE_LOW);
            S_WR_HIGH: ph_len = TW'(WE_HIGH);
            S_RD_LOW:  ph_len = TW'(RD_LOW);
            default:   ph_len = TW'(1);
        endcase
        unique case (op_q)
            OP_PROG: limit = CW'(LIM_PROG);
            OP_SECT: limit = CW'(LIM_SECT);
            default: limit = CW'(LIM_CHIP);
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_WR_LOW;
            S_WR_LOW:  if (ph_last)   nxt = S_WR_HIGH;
            S_WR_HIGH: if (ph_last)   nxt = last_step ? S_TURN : S_WR_LOW;
            S_TURN:    nxt = S_RD_LOW;
            S_RD_LOW:  if (ph_last)   nxt = match ? S_FIN : (at_limit ? S_ERR : S_TURN);
            S_FIN:     nxt = S_IDLE;
            S_ERR:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // request latch and script step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            step_q <= '0;
        end else if (accept) begin
            op_q   <= flash_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            step_q <= '0;
        end else if ((state == S_WR_HIGH) && ph_last && !last_step) begin
            step_q <= step_q + STEP_W'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        f_ce_n    = 1'b1;
        f_oe_n    = 1'b1;
        f_we_n    = 1'b1;
        f_dq_oe   = 1'b0;
        f_addr    = '0;
        f_dq_o    = '0;
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_WR_LOW: begin
                f_ce_n  = 1'b0;
                f_we_n  = 1'b0;
                f_dq_oe = 1'b1;
                f_addr  = cmd_addr;
                f_dq_o  = cmd_data;
            end
            S_WR_HIGH: begin
                f_ce_n  = 1'b0;
                f_dq_oe = 1'b1;
                f_addr  = cmd_addr;
                f_dq_o  = cmd_data;
            end
            S_TURN: begin
                f_ce_n = 1'b0;
                f_addr = poll_addr;
            end
            S_RD_LOW: begin
                f_ce_n = 1'b0;
                f_oe_n = 1'b0;
                f_addr = poll_addr;
            end
            S_FIN:   done = 1'b1;
            S_ERR:   err  = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    // checker state: length of the current write-strobe low run
    logic [TW:0] we_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    we_run <= '0;
        else if (f_we_n)               we_run <= '0;
        else if (we_run != {(TW+1){1'b1}}) we_run <= we_run + (TW+1)'(1);
    end

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_we_n) |-> (int'(we_run) == WE_LOW));

    // R5
    we_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> (!f_ce_n && f_oe_n && f_dq_oe));

    // R6
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_oe_n) |-> $past(!f_dq_oe));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_oe_n |-> !f_dq_oe);

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(done || err));

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> (req_ready && !done && !err));

    // R9
    end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int AW = 16;
    localparam int WL = 3;
    localparam int WH = 2;
    localparam int RL = 2;
    localparam int LP = 6;
    localparam int LS = 10;
    localparam int LC = 14;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data;
    logic          done, err;
    logic          f_ce_n, f_oe_n, f_we_n, f_dq_oe;
    logic [AW-1:0] f_addr;
    logic [7:0]    f_dq_o, f_dq_i;

    flash_cmd_seq #(
        .AW(AW), .SECT_LSB(12), .WE_LOW(WL), .WE_HIGH(WH), .RD_LOW(RL),
        .LIM_PROG(LP), .LIM_SECT(LS), .LIM_CHIP(LC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .done(done), .err(err), .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n),
        .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe), .f_dq_i(f_dq_i)
    );

    typedef struct packed {
        logic          rdy;
        logic          ce;
        logic          oe;
        logic          we;
        logic          doe;
        logic [15:0]   a;
        logic [7:0]    d;
        logic          dn;
        logic          er;
    } vec_t;

    vec_t  exp_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    ended = 1'b0;
    string cur_tag = "R10";

    // flash device model: DQ6 flips on every read while busy, then holds
    int   busy_reads = 0;
    int   rd_cnt = 0;
    logic dq6_v = 1'b0;
    assign f_dq_i = {1'b0, dq6_v, 6'b000000};

    always @(negedge f_oe_n) begin
        rd_cnt = rd_cnt + 1;
        if (rd_cnt <= busy_reads) dq6_v = rd_cnt[0];
        else if (busy_reads == 0) dq6_v = 1'b1;
        else dq6_v = busy_reads[0];
    end

    function automatic vec_t mk(logic r, logic c, logic o, logic w, logic de,
                                logic [15:0] a, logic [7:0] d, logic dn, logic er);
        vec_t v;
        v.rdy = r; v.ce = c; v.oe = o; v.we = w; v.doe = de;
        v.a = a; v.d = d; v.dn = dn; v.er = er;
        return v;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // reference trace for one operation, one entry per clock
    task automatic build(logic [1:0] op, logic [15:0] a, logic [7:0] d, int busy);
        logic [15:0] sa [0:5];
        logic [7:0]  sd [0:5];
        logic [15:0] pa;
        logic [15:0] base;
        int n, lim, kmatch, nrd;
        base = {a[15:12], 12'h000};
        sa[0] = 16'h5555; sd[0] = 8'hAA;
        sa[1] = 16'h2AAA; sd[1] = 8'h55;
        sa[2] = 16'h5555; sd[2] = 8'h80;
        sa[3] = 16'h5555; sd[3] = 8'hAA;
        sa[4] = 16'h2AAA; sd[4] = 8'h55;
        if (op == 2'b00) begin
            n = 4; lim = LP; pa = a;
            sd[2] = 8'hA0; sa[3] = a; sd[3] = d;
        end else if (op == 2'b01) begin
            n = 6; lim = LS; pa = base;
            sa[5] = base; sd[5] = 8'h30;
        end else begin
            n = 6; lim = LC; pa = 16'h0000;
            sa[5] = 16'h5555; sd[5] = 8'h10;
        end
        for (int s = 0; s < n; s++) begin
            repeat (WL) exp_q.push_back(mk(0, 0, 1, 0, 1, sa[s], sd[s], 0, 0));
            repeat (WH) exp_q.push_back(mk(0, 0, 1, 1, 1, sa[s], sd[s], 0, 0));
        end
        kmatch = (busy + 1 < 2) ? 2 : busy + 1;
        nrd    = (kmatch < lim) ? kmatch : lim;
        for (int r = 0; r < nrd; r++) begin
            exp_q.push_back(mk(0, 0, 1, 1, 0, pa, 8'h00, 0, 0));
            repeat (RL) exp_q.push_back(mk(0, 0, 0, 1, 0, pa, 8'h00, 0, 0));
        end
        exp_q.push_back(mk(0, 1, 1, 1, 0, 16'h0000, 8'h00, kmatch <= lim, kmatch > lim));
    endtask

    // per-cycle comparison against the reference trace
    always @(negedge clk) begin
        vec_t e;
        if (rst_n === 1'b1 && !ended) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = mk(1, 1, 1, 1, 0, 16'h0000, 8'h00, 0, 0);
            chk("R1", "req_ready", req_ready, e.rdy);
            chk("R5", "f_ce_n", f_ce_n, e.ce);
            chk("R7", "f_oe_n", f_oe_n, e.oe);
            chk("R5", "f_we_n", f_we_n, e.we);
            chk("R6", "f_dq_oe", f_dq_oe, e.doe);
            chk(cur_tag, "f_addr", f_addr, e.a);
            chk(cur_tag, "f_dq_o", f_dq_o, e.d);
            chk("R8", "done", done, e.dn);
            chk("R9", "err", err, e.er);
        end
    end

    task automatic run_op(logic [1:0] op, logic [15:0] a, logic [7:0] d, int busy, int hold);
        @(negedge clk);
        chk("R1", "ready before request", req_ready, 1);
        busy_reads = busy;
        rd_cnt     = 0;
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = a;
        req_data   = d;
        cur_tag    = (op == 2'b00) ? "R2" : ((op == 2'b01) ? "R3" : "R4");
        @(posedge clk);
        #1;
        build(op, a, d, busy);
        // R1: request fields change while busy and must be ignored
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            req_op   = ~op;
            req_addr = ~a;
            req_data = ~d;
        end
        @(negedge clk);
        req_valid = 1'b0;
        wait (exp_q.size() == 0);
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_op    = 2'b00;
        req_addr  = '0;
        req_data  = '0;
        repeat (2) @(negedge clk);
        // R10: reset state of the bus
        chk("R10", "reset f_ce_n", f_ce_n, 1);
        chk("R10", "reset f_oe_n", f_oe_n, 1);
        chk("R10", "reset f_we_n", f_we_n, 1);
        chk("R10", "reset f_dq_oe", f_dq_oe, 0);
        chk("R10", "reset f_addr", f_addr, 0);
        chk("R1", "reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(2'b00, 16'h1234, 8'h5A, 3, 3);   // R2 program, done, busy inputs ignored
        run_op(2'b01, 16'hB7C3, 8'hFF, 0, 0);   // R3 sector base masking, quick match
        run_op(2'b10, 16'h4321, 8'h00, 13, 0);  // R8 chip: match on limit read is done
        run_op(2'b00, 16'hFFFF, 8'hC3, 6, 1);   // R9 program: one read past limit -> err
        run_op(2'b11, 16'h0001, 8'h00, 2, 0);   // R4 alternate chip code
        run_op(2'b01, 16'h0FFF, 8'h11, 9, 2);   // R7 sector: match on limit read
        run_op(2'b01, 16'h5000, 8'h00, 30, 0);  // R9 sector never settles
        run_op(2'b10, 16'h8000, 8'h00, 20, 0);  // R9 chip never settles
        run_op(2'b00, 16'h0000, 8'hFF, 1, 2);   // R2 program at address 0
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

endmodule